// File: doc/BRIEF.md
# Bus-State Qualified I/O Select Decoder

This block produces eight active-low peripheral selects for a processor bus with an 8-bit data path and a 16-bit address. The processor reports a two-bit bus-state code with every cycle. Bit 1 means the cycle carries a valid data address and bit 0 means it carries a valid program address. A select may fire only when three things hold at once: the upper address byte points at the I/O page, the bus-state code marks a plain data access, and the processor clock phase is high.

An indexed store goes through an internal cycle while the processor adds the index. In that cycle the high address byte can already sit on the bus while the low byte is still wrong. The bus-state code is 00 in that cycle, so the decoder blocks every select. The correct device is then selected in the next cycle, once the address is final.

Each of the eight device slots covers 32 consecutive bytes of the page. The low five address bits pick a register inside the device and play no part in the decode. The block is purely combinational between its inputs and its selects.

Top module: `io_bus_decoder`

## Requirements
- R1: With bus-state code 10, clock phase high and address bits [15:8] equal to 0xD0, exactly one select is low. Its index is address bits [7:5], so 0xD000 gives select 0 and 0xD0E0 gives select 7.
- R2: With bus-state code 00 (internal operation), all eight selects stay high, even when the address lies in the I/O page.
- R3: With bus-state code 01 (program address) or 11 (opcode fetch), all selects stay high for every address.
- R4: An address whose bits [15:8] differ from 0xD0 leaves all selects high, whatever the bus-state code and phase.
- R5: While the clock phase input is low, all selects stay high.
- R6: At no time is more than one select low.
- R7: The read/write input has no effect. A read and a write to the same qualified address give the same select.
- R8: In an indexed-store sequence the selects stay high through the opcode, operand and internal cycles, including the internal cycle whose address is 0xD0 with a transient low byte. Exactly one select pulse occurs, in the final data cycle, on the slot of the final address.
- R9: Address bits [4:0] do not change which select asserts. All 32 offsets inside a slot select the same device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 16 | Processor address bus |
| bus_state | input | 2 | Bus-state code {valid data, valid program} |
| phase_hi | input | 1 | Processor clock phase, high in the data half of the cycle |
| rd_wr | input | 1 | 1 for a read, 0 for a write; does not affect the decode |
| dev_sel_n | output | 8 | Active-low device selects, one per 32-byte slot |

## Verification
Two things can meet in one cycle. The first is the page match on the upper address byte. The second is the bus-state qualification, which must suppress an internal or fetch cycle. The bench provokes this by holding an I/O-page address steady while it steps the bus-state code through all four values. It also plays an indexed store whose internal cycle carries 0xD0 in the high byte with a wrong low byte. It judges the result by counting select pulses over the whole sequence: exactly one is expected, and only in the final data cycle, on the slot of the final address.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef enum logic [1:0] {
    BS_INTERNAL = 2'b00,
    BS_PROGRAM  = 2'b01,
    BS_DATA     = 2'b10,
    BS_FETCH    = 2'b11
  } bus_state_t;

endpackage

// File: rtl/io_state_qual.sv
module io_state_qual
  import io_dec_pkg::*;
(
  input  logic [1:0] state_code,
  input  logic       phase_hi,
  output logic       access_ok
);
  bus_state_t st;

  always_comb begin
    st        = bus_state_t'(state_code);
    access_ok = phase_hi && (st == BS_DATA);
  end

  always_comb begin
    if (access_ok) begin
      AST_QUAL_ONLY_DATA: assert (state_code[1] && !state_code[0]); // R3
    end
  end
endmodule

// File: rtl/io_page_match.sv
module io_page_match #(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_LSB  = 8,
  parameter logic [15:0] PAGE_BASE = 16'hD000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_page
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam logic [PAGE_W-1:0] PAGE_TAG = PAGE_BASE[ADDR_W-1:PAGE_LSB];

  always_comb in_page = (addr[ADDR_W-1:PAGE_LSB] == PAGE_TAG);
endmodule

// File: rtl/io_slot_decode.sv
module io_slot_decode #(
  parameter int SLOT_BITS = 3
) (
  input  logic                    enable,
  input  logic [SLOT_BITS-1:0]    slot,
  output logic [(1<<SLOT_BITS)-1:0] sel_n
);
  localparam int NUM_SLOTS = 1 << SLOT_BITS;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign sel_n[g] = ~(enable && (slot == SLOT_BITS'(g)));
  end

  always_comb begin
    AST_ONE_HOT_LOW: assert ($onehot0(~sel_n)); // R6
  end
endmodule

// File: rtl/io_bus_decoder.sv
module io_bus_decoder
  import io_dec_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          SLOT_BITS = 3,
  parameter int          SPAN_BITS = 5,
  parameter logic [15:0] PAGE_BASE = 16'hD000
) (
  input  logic                       [ADDR_W-1:0] bus_addr,
  input  logic                       [1:0]        bus_state,
  input  logic                                    phase_hi,
  input  logic                                    rd_wr,
  output logic [(1<<SLOT_BITS)-1:0]               dev_sel_n
);
  localparam int NUM_SLOTS = 1 << SLOT_BITS;
  localparam int PAGE_LSB  = SLOT_BITS + SPAN_BITS;

  logic access_ok;
  logic in_page;

  io_state_qual u_qual (
    .state_code (bus_state),
    .phase_hi   (phase_hi),
    .access_ok  (access_ok)
  );

  io_page_match #(
    .ADDR_W    (ADDR_W),
    .PAGE_LSB  (PAGE_LSB),
    .PAGE_BASE (PAGE_BASE)
  ) u_page (
    .addr    (bus_addr),
    .in_page (in_page)
  );

  io_slot_decode #(
    .SLOT_BITS (SLOT_BITS)
  ) u_slot (
    .enable (access_ok && in_page),
    .slot   (bus_addr[PAGE_LSB-1:SPAN_BITS]),
    .sel_n  (dev_sel_n)
  );

  always_comb begin
    if (bus_state == BS_INTERNAL) begin
      AST_NO_SEL_INTERNAL: assert (&dev_sel_n); // R2
    end
    if (bus_state == BS_PROGRAM || bus_state == BS_FETCH) begin
      AST_NO_SEL_FETCH: assert (&dev_sel_n); // R3
    end
    if (!phase_hi) begin
      AST_NO_SEL_PHASE_LOW: assert (&dev_sel_n); // R5
    end
    if (!in_page) begin
      AST_NO_SEL_OFF_PAGE: assert (&dev_sel_n); // R4
    end
    if (!(&dev_sel_n)) begin
      AST_SEL_NEEDS_ALL: assert (bus_state == BS_DATA && phase_hi && in_page
                                 && (rd_wr || !rd_wr)); // R1
    end
    if (bus_state == BS_DATA && phase_hi && in_page) begin
      AST_SEL_SLOT_MATCH: assert (!dev_sel_n[bus_addr[PAGE_LSB-1:SPAN_BITS]]); // R7
    end
  end

  if (NUM_SLOTS < 2) begin : g_bad_cfg
    $error("io_bus_decoder needs at least two slots");
  end
endmodule

// File: tb/tb_io_bus_decoder.sv
module tb_io_bus_decoder;
  logic        clk = 1'b0;
  logic [15:0] bus_addr  = 16'h0000;
  logic [1:0]  bus_state = 2'b00;
  logic        phase_hi  = 1'b0;
  logic        rd_wr     = 1'b1;
  logic [7:0]  dev_sel_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  io_bus_decoder dut (
    .bus_addr  (bus_addr),
    .bus_state (bus_state),
    .phase_hi  (phase_hi),
    .rd_wr     (rd_wr),
    .dev_sel_n (dev_sel_n)
  );

  // {addr[15:0], state[1:0], phase, rd_wr, expected[7:0]}
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {16'hD000, 2'b10, 1'b1, 1'b0, 8'hFE},  // R1 slot 0
    {16'hD020, 2'b10, 1'b1, 1'b1, 8'hFD},  // R1 slot 1
    {16'hD05F, 2'b10, 1'b1, 1'b0, 8'hFB},  // R1 slot 2
    {16'hD0BF, 2'b10, 1'b1, 1'b1, 8'hDF},  // R1 slot 5
    {16'hD0E5, 2'b10, 1'b1, 1'b0, 8'h7F},  // R1 slot 7
    {16'hD000, 2'b00, 1'b1, 1'b0, 8'hFF},  // R2
    {16'hD0E0, 2'b00, 1'b1, 1'b1, 8'hFF},  // R2
    {16'hD0A0, 2'b01, 1'b1, 1'b1, 8'hFF},  // R3
    {16'hD0A0, 2'b11, 1'b1, 1'b1, 8'hFF},  // R3
    {16'hD100, 2'b10, 1'b1, 1'b0, 8'hFF},  // R4
    {16'hC0E0, 2'b10, 1'b1, 1'b0, 8'hFF},  // R4
    {16'h5000, 2'b10, 1'b1, 1'b1, 8'hFF},  // R4
    {16'hD0A0, 2'b10, 1'b0, 1'b0, 8'hFF},  // R5
    {16'hD000, 2'b10, 1'b0, 1'b1, 8'hFF},  // R5
    {16'hD07F, 2'b10, 1'b1, 1'b0, 8'hF7},  // R7 write
    {16'hD07F, 2'b10, 1'b1, 1'b1, 8'hF7}   // R7 read
  };

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (dev_sel_n !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h state=%b phase=%b rw=%b got=%h exp=%h",
               req, bus_addr, bus_state, phase_hi, rd_wr, dev_sel_n, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [1:0] s,
                       input logic p, input logic rw);
    @(posedge clk);
    bus_addr  = a;
    bus_state = s;
    phase_hi  = p;
    rd_wr     = rw;
    @(negedge clk);
  endtask

  int pulses;
  int pulse_ok;

  task automatic bus_cycle(input logic [15:0] a, input logic [1:0] s,
                           input logic rw, input logic [7:0] exp_hi);
    drive(a, s, 1'b0, rw);
    if (dev_sel_n !== 8'hFF) pulses++;
    drive(a, s, 1'b1, rw);
    if (dev_sel_n !== 8'hFF) begin
      pulses++;
      if (dev_sel_n === exp_hi && exp_hi !== 8'hFF) pulse_ok++;
    end
    check("R8 cycle", exp_hi);
  endtask

  initial begin
    // idle bus: internal state, phase low
    drive(16'h0000, 2'b00, 1'b0, 1'b1);
    check("R2 idle", 8'hFF);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][27:12], VEC[i][11:10], VEC[i][9], VEC[i][8]);
      check("R1-table", VEC[i][7:0]);
    end

    // R2/R3: same page address through all four state codes
    for (int s = 0; s < 4; s++) begin
      drive(16'hD0C4, 2'(s), 1'b1, 1'b0);
      check("R2/R3 state sweep", (s == 2) ? 8'hBF : 8'hFF);
    end

    // R9: every offset of slot 6 selects the same device
    for (int off = 0; off < 32; off++) begin
      drive(16'hD0C0 + 16'(off), 2'b10, 1'b1, 1'b0);
      check("R9 offset", 8'hBF);
    end

    // R8: indexed store to base D000 + index 5
    pulses = 0;
    pulse_ok = 0;
    bus_cycle(16'hE268, 2'b11, 1'b1, 8'hFF);  // opcode fetch
    bus_cycle(16'hE269, 2'b01, 1'b1, 8'hFF);  // operand low
    bus_cycle(16'hE26A, 2'b01, 1'b1, 8'hFF);  // operand high
    bus_cycle(16'hD0E0, 2'b00, 1'b1, 8'hFF);  // internal, transient low byte
    bus_cycle(16'hD005, 2'b10, 1'b0, 8'hFE);  // final store to slot 0
    checks++;
    if (pulses != 1 || pulse_ok != 1) begin
      errors++;
      $display("FAIL R8 pulse count: got=%0d (on final slot %0d) exp=1", pulses, pulse_ok);
    end

    // R6: sweep the whole page and see at most one select low
    for (int a = 0; a < 256; a++) begin
      drive(16'hD000 + 16'(a), 2'b10, 1'b1, 1'b1);
      checks++;
      if ($countones(~dev_sel_n) > 1) begin
        errors++;
        $display("FAIL R6: got=%h exp=at most one low", dev_sel_n);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule